// File: doc/BRIEF.md
# Parallel Flash Bus-Mode Controller

This block sits between the parallel pins of an on-chip flash array and the array itself. It passes the active-low chip, output and write enables, the active-low power-down pin, the area-select pin, the address and the incoming data through two-flop synchronizers into the system clock domain. From the synchronized pins it works out the current bus mode (read, output off, standby, write or power-down) and drives the data output and its enable for an external pad cell.

Command, address and data are taken on the first rising edge of the combined enable, which is the OR of write-enable and chip-enable. A small command machine decodes the byte. It selects whether reads return array data or the status register, clears error flags, and starts program and block-erase operations once their second cycle arrives. A busy counter stands in for the program and erase time. While it runs, the status register reports not-ready. A program or erase starts with a one-cycle strobe towards the array. Pulling the power-down pin low aborts any running operation and flags the target block as invalid.

Top module: `pflash_bus_ctrl`

## Requirements
- R1: The data output enable `dq_oe` is 1 only while the synchronized pins show chip-enable low, output-enable low, write-enable high and power-down high. `dq_out` then carries `array_rdata` in read-array mode, or the status byte in read-status mode.
- R2: In output-off mode (chip low, output and write high), in standby (chip high), during a write and during power-down, `dq_oe` is 0.
- R3: A command or data byte is captured once, on the rising edge of (we_n OR ce_n), with output-enable and power-down high. When chip-enable rises first, that edge is the capture point, and the later rise of write-enable captures nothing.
- R4: Command 0xFF selects read-array mode and 0x70 selects read-status mode. Command 0x50 clears status bits 5 and 4.
- R5: Command 0x40 followed by a data cycle at a valid address gives exactly one `array_prog` pulse, carrying that address and data. The part is then busy (status bit 7 = 0) for PROG_CYCLES cycles and returns to ready on its own. Commands 0x40 and 0x20 switch reads to status.
- R6: Command 0x20 followed by 0xD0 at a valid address gives one `array_erase` pulse and a busy time of ERASE_CYCLES cycles. Any other second byte sets status bits 5 and 4 and does not erase.
- R7: With area-select low, valid addresses are 0x1000–0xFFFF. With area-select high (boot area), they are 0xF000–0xFFFF. An out-of-range program sets status bit 4, an out-of-range erase sets bit 5, and no strobe is issued.
- R8: The block number in `array_blk` is 0 for a user-area address below 0x8000 and 1 for a user-area address at or above it. Any boot-area address gives 2, so the whole 4 KB boot block is the erase unit.
- R9: The status byte is {ready, 0, erase error, program error, 0000}. It reads 0x80 after reset.
- R10: While busy, only 0x70 is accepted. Every other byte, including 0xFF, is ignored.
- R11: Standby (chip-enable high) does not stop a running program or erase. The operation still completes and the part becomes ready.
- R12: Power-down low while busy gives one `blk_invalid` pulse, with the aborted block in `array_blk`. After power-down the status reads 0x80.
- R13: Read-array mode is selected after reset and after leaving power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| pd_n | input | 1 | Power-down pin, active low |
| area_sel | input | 1 | 0 = user area, 1 = boot area |
| addr | input | 16 | Address pins |
| dq_in | input | 8 | Data bus input from pad |
| dq_out | output | 8 | Data bus output to pad |
| dq_oe | output | 1 | Pad output enable |
| array_raddr | output | 16 | Synchronized read address to array |
| array_rdata | input | 8 | Array read data |
| array_waddr | output | 16 | Program/erase target address |
| array_wdata | output | 8 | Program data |
| array_prog | output | 1 | One-cycle program start strobe |
| array_erase | output | 1 | One-cycle erase start strobe |
| array_blk | output | 2 | Target block number of the last operation |
| blk_invalid | output | 1 | One-cycle pulse: operation aborted, block invalid |

## Verification
The bench targets the edges of the address windows: user-area addresses just under 0x1000, boot-area addresses under 0xF000, and user blocks on either side of 0x8000. A design with a wrong comparison either programs a forbidden location or refuses a legal one. It releases chip-enable before write-enable to catch a design that captures twice, or only on the write-enable rise. It also sends 0xFF during a busy period, which would flip reads back to array data if busy filtering were missing. Standby and power-down are applied mid-operation: a design that halts on standby never becomes ready, and one that ignores power-down gives no invalid-block pulse and keeps stale error flags.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [2:0] {
    BM_POWERDOWN,
    BM_STANDBY,
    BM_READ,
    BM_OUTOFF,
    BM_WRITE,
    BM_ILLEGAL
  } bus_mode_e;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_PROG_DATA,
    CS_ERASE_CONF,
    CS_PROG_BUSY,
    CS_ERASE_BUSY
  } cmd_state_e;

  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_READ_STATUS = 8'h70;
  localparam logic [7:0] OP_CLEAR_STAT  = 8'h50;
  localparam logic [7:0] OP_PROGRAM     = 8'h40;
  localparam logic [7:0] OP_ERASE       = 8'h20;
  localparam logic [7:0] OP_CONFIRM     = 8'hD0;

  // address window check: boot area starts higher than user area
  function automatic logic addr_ok(input logic boot, input logic [31:0] a,
                                   input logic [31:0] user_base,
                                   input logic [31:0] boot_base);
    return boot ? (a >= boot_base) : (a >= user_base);
  endfunction

  // block numbering: user low half 0, user high half 1, boot 2
  function automatic logic [1:0] block_of(input logic boot, input logic [31:0] a,
                                          input logic [31:0] split);
    if (boot) return 2'd2;
    return (a >= split) ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [7:0] make_status(input logic ready, input logic e_err,
                                             input logic p_err);
    return {ready, 1'b0, e_err, p_err, 4'b0000};
  endfunction

endpackage

// File: rtl/pflash_sync.sv
module pflash_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pflash_mode_dec.sv
module pflash_mode_dec
  import pflash_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      we_n,
  input  logic      pd_n,
  output bus_mode_e mode,
  output logic      wr_stb
);
  logic en_n, en_q;

  always_comb begin
    if (!pd_n)                 mode = BM_POWERDOWN;
    else if (ce_n)             mode = BM_STANDBY;
    else if (!we_n &&  oe_n)   mode = BM_WRITE;
    else if ( we_n && !oe_n)   mode = BM_READ;
    else if ( we_n &&  oe_n)   mode = BM_OUTOFF;
    else                       mode = BM_ILLEGAL;
  end

  // combined enable: goes high at whichever of we_n / ce_n rises first
  assign en_n = we_n | ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_n;
  end

  assign wr_stb = !en_q && en_n && oe_n && pd_n;
endmodule

// File: rtl/pflash_cmd_ctrl.sv
module pflash_cmd_ctrl
  import pflash_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned USER_BASE    = 32'h1000,
  parameter int unsigned BOOT_BASE    = 32'hF000,
  parameter int unsigned USER_SPLIT   = 32'h8000,
  parameter int unsigned PROG_CYCLES  = 40,
  parameter int unsigned ERASE_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_active,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_area,
  output logic              rd_status,
  output logic [7:0]        status,
  output logic              busy,
  output logic              array_prog,
  output logic              array_erase,
  output logic [ADDR_W-1:0] array_waddr,
  output logic [DATA_W-1:0] array_wdata,
  output logic [1:0]        array_blk,
  output logic              blk_invalid
);
  localparam int unsigned MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  cmd_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic               err_p, err_e;
  logic               in_range;
  logic [1:0]         blk_n;
  logic [7:0]         cmd;

  assign cmd      = 8'(wr_data);
  assign in_range = addr_ok(wr_area, 32'(wr_addr), USER_BASE, BOOT_BASE);
  assign blk_n    = block_of(wr_area, 32'(wr_addr), USER_SPLIT);
  assign busy     = (state == CS_PROG_BUSY) || (state == CS_ERASE_BUSY);
  assign status   = make_status(!busy, err_e, err_p);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= CS_IDLE;
      cnt         <= '0;
      err_p       <= 1'b0;
      err_e       <= 1'b0;
      rd_status   <= 1'b0;
      array_prog  <= 1'b0;
      array_erase <= 1'b0;
      array_waddr <= '0;
      array_wdata <= '0;
      array_blk   <= '0;
      blk_invalid <= 1'b0;
    end else if (pd_active) begin
      blk_invalid <= busy;
      state       <= CS_IDLE;
      cnt         <= '0;
      err_p       <= 1'b0;
      err_e       <= 1'b0;
      rd_status   <= 1'b0;
      array_prog  <= 1'b0;
      array_erase <= 1'b0;
    end else begin
      blk_invalid <= 1'b0;
      array_prog  <= 1'b0;
      array_erase <= 1'b0;
      case (state)
        CS_IDLE: if (wr_stb) begin
          case (cmd)
            OP_READ_ARRAY:  rd_status <= 1'b0;
            OP_READ_STATUS: rd_status <= 1'b1;
            OP_CLEAR_STAT: begin
              err_p <= 1'b0;
              err_e <= 1'b0;
            end
            OP_PROGRAM: begin
              rd_status <= 1'b1;
              state     <= CS_PROG_DATA;
            end
            OP_ERASE: begin
              rd_status <= 1'b1;
              state     <= CS_ERASE_CONF;
            end
            default: ;
          endcase
        end
        CS_PROG_DATA: if (wr_stb) begin
          if (in_range) begin
            array_prog  <= 1'b1;
            array_waddr <= wr_addr;
            array_wdata <= wr_data;
            array_blk   <= blk_n;
            cnt         <= CNT_W'(PROG_CYCLES - 1);
            state       <= CS_PROG_BUSY;
          end else begin
            err_p <= 1'b1;
            state <= CS_IDLE;
          end
        end
        CS_ERASE_CONF: if (wr_stb) begin
          if (cmd != OP_CONFIRM) begin
            err_p <= 1'b1;
            err_e <= 1'b1;
            state <= CS_IDLE;
          end else if (in_range) begin
            array_erase <= 1'b1;
            array_waddr <= wr_addr;
            array_blk   <= blk_n;
            cnt         <= CNT_W'(ERASE_CYCLES - 1);
            state       <= CS_ERASE_BUSY;
          end else begin
            err_e <= 1'b1;
            state <= CS_IDLE;
          end
        end
        CS_PROG_BUSY, CS_ERASE_BUSY: begin
          if (wr_stb && cmd == OP_READ_STATUS) rd_status <= 1'b1;
          if (cnt == '0) state <= CS_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pflash_bus_ctrl.sv
module pflash_bus_ctrl
  import pflash_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned USER_BASE    = 32'h1000,
  parameter int unsigned BOOT_BASE    = 32'hF000,
  parameter int unsigned USER_SPLIT   = 32'h8000,
  parameter int unsigned PROG_CYCLES  = 40,
  parameter int unsigned ERASE_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              pd_n,
  input  logic              area_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] array_raddr,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [ADDR_W-1:0] array_waddr,
  output logic [DATA_W-1:0] array_wdata,
  output logic              array_prog,
  output logic              array_erase,
  output logic [1:0]        array_blk,
  output logic              blk_invalid
);
  localparam int unsigned CTL_W = 5;
  localparam int unsigned DAT_W = ADDR_W + DATA_W;

  logic [CTL_W-1:0] ctl_s;
  logic [DAT_W-1:0] dat_s;
  logic s_ce_n, s_oe_n, s_we_n, s_pd_n, s_area;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_dq;
  bus_mode_e mode_w;
  logic wr_stb_w, rd_status_w, busy_w;
  logic [7:0] status_w;

  pflash_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b01111)) ctl_sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({area_sel, pd_n, we_n, oe_n, ce_n}), .q(ctl_s));

  pflash_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) dat_sync_i (
    .clk(clk), .rst_n(rst_n), .d({addr, dq_in}), .q(dat_s));

  assign {s_area, s_pd_n, s_we_n, s_oe_n, s_ce_n} = ctl_s;
  assign {s_addr, s_dq} = dat_s;

  pflash_mode_dec mode_i (
    .clk(clk), .rst_n(rst_n), .ce_n(s_ce_n), .oe_n(s_oe_n), .we_n(s_we_n),
    .pd_n(s_pd_n), .mode(mode_w), .wr_stb(wr_stb_w));

  pflash_cmd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .USER_BASE(USER_BASE), .BOOT_BASE(BOOT_BASE),
    .USER_SPLIT(USER_SPLIT), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) cmd_i (
    .clk(clk), .rst_n(rst_n), .pd_active(!s_pd_n), .wr_stb(wr_stb_w),
    .wr_addr(s_addr), .wr_data(s_dq), .wr_area(s_area),
    .rd_status(rd_status_w), .status(status_w), .busy(busy_w),
    .array_prog(array_prog), .array_erase(array_erase),
    .array_waddr(array_waddr), .array_wdata(array_wdata),
    .array_blk(array_blk), .blk_invalid(blk_invalid));

  assign array_raddr = s_addr;
  assign dq_oe       = (mode_w == BM_READ);
  assign dq_out      = rd_status_w ? DATA_W'(status_w) : array_rdata;
endmodule

// File: rtl/pflash_bus_ctrl_chk.sv
module pflash_bus_ctrl_chk #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned USER_BASE   = 32'h1000,
  parameter int unsigned BOOT_BASE   = 32'hF000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              pd_n,
  input logic              dq_oe,
  input logic              array_prog,
  input logic              array_erase,
  input logic [ADDR_W-1:0] array_waddr,
  input logic [1:0]        array_blk,
  input logic              blk_invalid,
  input logic              busy_w,
  input logic [7:0]        status_w,
  input logic              s_pd_n
);
  assert_drive_only_in_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ($past(pd_n, SYNC_STAGES) && !$past(ce_n, SYNC_STAGES) &&
               !$past(oe_n, SYNC_STAGES) && $past(we_n, SYNC_STAGES)));

  assert_single_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(array_prog && array_erase));

  assert_prog_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    array_prog |-> ((array_blk == 2'd2) ? (32'(array_waddr) >= BOOT_BASE)
                                        : (32'(array_waddr) >= USER_BASE)));

  assert_no_start_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_w) |-> (!array_prog && !array_erase));

  assert_abort_needs_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    blk_invalid |-> $past(busy_w));

  assert_pd_status_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!s_pd_n) |-> (status_w == 8'h80));

  assert_status_spare_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w & 8'h4F) == 8'h00);
endmodule

bind pflash_bus_ctrl pflash_bus_ctrl_chk #(
  .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .USER_BASE(USER_BASE), .BOOT_BASE(BOOT_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .pd_n(pd_n),
  .dq_oe(dq_oe), .array_prog(array_prog), .array_erase(array_erase),
  .array_waddr(array_waddr), .array_blk(array_blk), .blk_invalid(blk_invalid),
  .busy_w(busy_w), .status_w(status_w), .s_pd_n(s_pd_n));

// File: tb/pflash_bus_ctrl_tb_top.sv
module pflash_bus_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pd_n = 1'b1, area_sel = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe;
  logic [15:0] array_raddr, array_waddr;
  logic [7:0]  array_rdata, array_wdata;
  logic        array_prog, array_erase, blk_invalid;
  logic [1:0]  array_blk;

  int total = 0, bad = 0;
  int n_prog = 0, n_erase = 0, n_inv = 0;
  logic [15:0] last_waddr;
  logic [7:0]  last_wdata;
  logic [1:0]  last_blk;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic exp_ok(input logic boot, input logic [15:0] a);
    if (boot) return a[15:12] == 4'hF;
    return a[15:12] != 4'h0;
  endfunction
  function automatic logic [1:0] exp_blk(input logic boot, input logic [15:0] a);
    return boot ? 2'd2 : {1'b0, a[15]};
  endfunction

  assign array_rdata = mem_f(array_raddr);

  pflash_bus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .pd_n(pd_n),
    .area_sel(area_sel), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .array_raddr(array_raddr), .array_rdata(array_rdata), .array_waddr(array_waddr),
    .array_wdata(array_wdata), .array_prog(array_prog), .array_erase(array_erase),
    .array_blk(array_blk), .blk_invalid(blk_invalid));

  always @(negedge clk) begin
    if (array_prog)  begin n_prog++;  last_waddr = array_waddr; last_wdata = array_wdata; last_blk = array_blk; end
    if (array_erase) begin n_erase++; last_waddr = array_waddr; last_blk = array_blk; end
    if (blk_invalid) begin n_inv++;   last_blk = array_blk; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic boot, input logic [15:0] a, input logic [7:0] d);
    area_sel = boot; addr = a; dq_in = d;
    ce_n = 1'b0; wcyc(3);
    we_n = 1'b0; wcyc(4);
    we_n = 1'b1; wcyc(4);
    ce_n = 1'b1; wcyc(3);
  endtask

  task automatic bus_wr_ce_first(input logic [15:0] a, input logic [7:0] d);
    addr = a; dq_in = d;
    ce_n = 1'b0; we_n = 1'b0; wcyc(4);
    ce_n = 1'b1; wcyc(4);
    we_n = 1'b1; wcyc(3);
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d, output logic oe);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; wcyc(4);
    d = dq_out; oe = dq_oe;
    oe_n = 1'b1; ce_n = 1'b1; wcyc(3);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    int p0, e0, i0;
    void'($urandom(32'd2024));
    wcyc(3); rst_n = 1'b1; wcyc(3);

    chk("R2 reset idle oe", dq_oe, 0);
    bus_rd(16'h1234, d, oe);
    chk("R13 reset array read", d, mem_f(16'h1234));
    chk("R1 read drives", oe, 1);

    ce_n = 0; wcyc(4); chk("R2 output off", dq_oe, 0); ce_n = 1; wcyc(3);
    oe_n = 0; wcyc(4); chk("R2 standby", dq_oe, 0); oe_n = 1; wcyc(3);
    ce_n = 0; we_n = 0; wcyc(4); chk("R2 write mode", dq_oe, 0); we_n = 1; ce_n = 1; wcyc(3);

    bus_wr(0, 16'h0000, 8'h70);
    bus_rd(16'h0000, d, oe); chk("R4 R9 status after reset", d, 8'h80);
    bus_wr(0, 16'h0000, 8'hFF);
    bus_rd(16'h4321, d, oe); chk("R4 read array", d, mem_f(16'h4321));
    bus_wr_ce_first(16'h0000, 8'h70);
    bus_rd(16'h0000, d, oe); chk("R3 ce-first capture", d, 8'h80);
    bus_wr(0, 16'h0000, 8'hFF);

    p0 = n_prog;
    bus_wr(0, 16'h2000, 8'h40); bus_wr(0, 16'h2000, 8'h3C);
    chk("R5 one prog pulse", n_prog - p0, 1);
    chk("R5 prog addr", last_waddr, 16'h2000);
    chk("R5 prog data", last_wdata, 8'h3C);
    bus_rd(16'h0, d, oe); chk("R5 busy status", d, 8'h00);
    bus_wr(0, 16'h0000, 8'hFF);
    bus_rd(16'h0, d, oe); chk("R10 ignore while busy", d, 8'h00);
    wcyc(60);
    bus_rd(16'h0, d, oe); chk("R5 ready again", d, 8'h80);

    p0 = n_prog;
    bus_wr(0, 16'h0FFF, 8'h40); bus_wr(0, 16'h0FFF, 8'h11);
    bus_rd(16'h0, d, oe); chk("R7 user low reject", d, 8'h90);
    chk("R7 no prog pulse", n_prog - p0, 0);
    bus_wr(0, 16'h0, 8'h50);
    bus_rd(16'h0, d, oe); chk("R4 clear status", d, 8'h80);
    bus_wr(1, 16'hEFFF, 8'h40); bus_wr(1, 16'hEFFF, 8'h22);
    bus_rd(16'h0, d, oe); chk("R7 boot reject", d, 8'h90);
    bus_wr(0, 16'h0, 8'h50);
    bus_wr(1, 16'hF123, 8'h40); bus_wr(1, 16'hF123, 8'h22);
    chk("R7 boot accept", n_prog - p0, 1);
    chk("R8 boot prog blk", last_blk, 2);
    wcyc(60);

    e0 = n_erase;
    bus_wr(0, 16'h9000, 8'h20); bus_wr(0, 16'h9000, 8'hD0);
    chk("R6 erase pulse", n_erase - e0, 1);
    chk("R8 user upper blk", last_blk, 1);
    wcyc(120);
    bus_rd(16'h0, d, oe); chk("R6 erase done", d, 8'h80);
    bus_wr(0, 16'h9000, 8'h20); bus_wr(0, 16'h9000, 8'h33);
    bus_rd(16'h0, d, oe); chk("R6 bad confirm", d, 8'hB0);
    chk("R6 no erase on bad confirm", n_erase - e0, 1);
    bus_wr(0, 16'h0, 8'h50);
    bus_wr(0, 16'h0400, 8'h20); bus_wr(0, 16'h0400, 8'hD0);
    bus_rd(16'h0, d, oe); chk("R7 erase reject", d, 8'hA0);
    bus_wr(0, 16'h0, 8'h50);
    bus_wr(1, 16'hF800, 8'h20); bus_wr(1, 16'hF800, 8'hD0);
    chk("R8 boot erase blk", last_blk, 2);
    wcyc(120);

    p0 = n_prog;
    bus_wr(0, 16'h7FFF, 8'h40); bus_wr(0, 16'h7FFF, 8'hA5);
    chk("R8 user lower blk", last_blk, 0);
    wcyc(10);
    bus_rd(16'h0, d, oe); chk("R11 busy through standby", d, 8'h00);
    wcyc(50);
    bus_rd(16'h0, d, oe); chk("R11 completes after standby", d, 8'h80);

    i0 = n_inv;
    bus_wr(0, 16'h3000, 8'h20); bus_wr(0, 16'h3000, 8'hD0);
    pd_n = 0; ce_n = 0; oe_n = 0; wcyc(5);
    chk("R2 pd hi-z", dq_oe, 0);
    chk("R12 invalid pulse", n_inv - i0, 1);
    chk("R12 invalid blk", last_blk, 0);
    oe_n = 1; ce_n = 1; pd_n = 1; wcyc(4);
    bus_rd(16'h5555, d, oe); chk("R13 array after pd", d, mem_f(16'h5555));
    bus_wr(0, 16'h0, 8'h70);
    bus_rd(16'h0, d, oe); chk("R12 status after pd", d, 8'h80);

    for (int k = 0; k < 16; k++) begin
      logic boot;
      logic [15:0] a;
      logic [7:0] v;
      boot = 1'($urandom % 2);
      a = 16'($urandom);
      if (k % 4 == 0) a = boot ? 16'hF000 - 16'(k) : 16'h1000 - 16'(k);
      v = 8'($urandom);
      p0 = n_prog;
      bus_wr(boot, a, 8'h40); bus_wr(boot, a, v);
      chk("R7 random accept count", n_prog - p0, {31'b0, exp_ok(boot, a)});
      if (exp_ok(boot, a)) begin
        chk("R5 random data", last_wdata, v);
        chk("R8 random blk", last_blk, exp_blk(boot, a));
      end
      wcyc(50);
      bus_rd(16'h0, d, oe);
      chk("R7 random status", d, exp_ok(boot, a) ? 8'h80 : 8'h90);
      bus_wr(0, 16'h0, 8'h50);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule